// File: doc/BRIEF.md
# DMA Control Port Decoder

This block sits behind the CPU port interface of a four-channel DMA engine and handles the eight control port indices, 8 through 15. A write to one of these ports can update the command byte, the per-channel mask bits, the software request bits or a channel mode byte. A write can also clear the byte pointer that the address and count logic keeps, or return the controller to its reset state. Reads of the status port and of the mask port are served from the registers kept here. Port indices below 8 belong to the address and count registers. This decoder ignores them.

The service arbiter receives the mask bits and the request bits from this block. It also receives the command and mode registers and a one-cycle pulse that clears the byte pointer. Request bits can be set or cleared in three ways: by CPU writes, by per-channel hold and release inputs from requesting devices, and by terminal-count inputs that latch completion into the low status bits. When an external event and a CPU write touch the same bit in the same cycle, the external event wins.

Top module: `dma_ctl_decoder`

## Requirements
- R1: After reset the mask is all ones (0xF), status is 0x00, the command register is 0x00, every mode byte is 0x00 and the pointer-clear pulse is low.
- R2: A write to port 8 loads the command register only when the data has no bit set other than bit 2, which means the data is 0x00 or 0x04. Any other value leaves the command register unchanged.
- R3: A write to port 9 selects channel c = data[1:0]. It sets status bit c+4 to data[2] and clears status bit c. Status bits 7:4 appear on req_out[3:0].
- R4: A write to port 10 sets mask bit data[1:0] when data[2] is 1 and clears that bit when data[2] is 0. No other mask bit changes.
- R5: A write to port 11 stores the whole data byte as the mode of channel data[1:0]. Channel c's mode appears on mode_out[8c+7:8c].
- R6: A write to port 12 drives ptr_clr high for exactly the one cycle that follows the write. Mask, status and command are unchanged.
- R7: A write to port 13 sets every mask bit and clears status and command. It also pulses ptr_clr as in R6. Mode bytes are unchanged.
- R8: A write to port 14 clears every mask bit. A write to port 15 loads mask[3:0] from data[3:0].
- R9: While rd_en is high and wr_en is low, rd_data shows the status byte for port 8, {4'b0, mask} for port 15 and 0x00 for any other port. A status read clears status bits 3:0 at the next clock edge.
- R10: hold_req[c] sets status bit c+4 and release_req[c] clears it. If both are high in the same cycle, the hold wins.
- R11: A hold or release on a channel takes priority over a CPU write to the same status bit in the same cycle, including a master reset.
- R12: tc_done[c] sets status bit c, and it takes priority over any clear of that bit in the same cycle.
- R13: Writes to port indices 0 through 7 leave command, mask, status and mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU port write strobe |
| rd_en | input | 1 | CPU port read strobe |
| port_idx | input | 4 | Port index of the access |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data, combinational |
| hold_req | input | 4 | Per-channel external request hold |
| release_req | input | 4 | Per-channel external request release |
| tc_done | input | 4 | Per-channel terminal-count event |
| mask_out | output | 4 | Channel mask bits |
| req_out | output | 4 | Request bits (status 7:4) |
| cmd_out | output | 8 | Command register |
| mode_out | output | 32 | Four mode bytes, channel 0 in the low byte |
| ptr_clr | output | 1 | One-cycle byte-pointer clear pulse |

## Verification
The command port receives all 256 data values in turn. This separates the two accepted values from every rejected value and shows that a rejected write keeps the previous value. The single-mask port is tried with all eight data codes against all sixteen starting masks, so a wrong bit index or a disturbed neighbour bit shows up. Request writes, holds, releases and terminal-count pulses are applied alone and in same-cycle pairs, which tests the priority order. Status reads are repeated back to back to show which bits the clear-on-read affects.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = 4;

  localparam logic [IDX_W-1:0] P_COMMAND  = 4'd8;
  localparam logic [IDX_W-1:0] P_SWREQ    = 4'd9;
  localparam logic [IDX_W-1:0] P_ONEMASK  = 4'd10;
  localparam logic [IDX_W-1:0] P_MODE     = 4'd11;
  localparam logic [IDX_W-1:0] P_PTRCLR   = 4'd12;
  localparam logic [IDX_W-1:0] P_MASTER   = 4'd13;
  localparam logic [IDX_W-1:0] P_MASKNONE = 4'd14;
  localparam logic [IDX_W-1:0] P_MASKALL  = 4'd15;

  // Command bits the controller can honour; anything else rejects the write.
  localparam logic [DATA_W-1:0] CMD_HONOURED = 8'h04;
  localparam int unsigned       SETBIT_POS   = 2;

  typedef struct packed {
    logic command;
    logic swreq;
    logic onemask;
    logic mode;
    logic ptrclr;
    logic master;
    logic masknone;
    logic maskall;
  } wr_strobe_t;

  function automatic logic cmd_is_legal(input logic [DATA_W-1:0] d);
    return (d & ~CMD_HONOURED) == '0;
  endfunction

  function automatic logic [DATA_W-1:0] read_select(
      input logic [IDX_W-1:0]  idx,
      input logic [DATA_W-1:0] status,
      input logic [DATA_W-1:0] mask_ext);
    if (idx == P_COMMAND)      return status;
    else if (idx == P_MASKALL) return mask_ext;
    else                       return '0;
  endfunction
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] port_idx,
  output wr_strobe_t       stb,
  output logic             status_rd
);
  always_comb begin
    stb = '0;
    if (wr_en) begin
      unique case (port_idx)
        P_COMMAND:  stb.command  = 1'b1;
        P_SWREQ:    stb.swreq    = 1'b1;
        P_ONEMASK:  stb.onemask  = 1'b1;
        P_MODE:     stb.mode     = 1'b1;
        P_PTRCLR:   stb.ptrclr   = 1'b1;
        P_MASTER:   stb.master   = 1'b1;
        P_MASKNONE: stb.masknone = 1'b1;
        P_MASKALL:  stb.maskall  = 1'b1;
        default:    stb          = '0;
      endcase
    end
  end

  // A read only counts as a status read when no write shares the cycle.
  assign status_rd = rd_en && !wr_en && (port_idx == P_COMMAND);
endmodule

// File: rtl/dma_ctl_mask.sv
module dma_ctl_mask #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           one_wr,
  input  logic           master,
  input  logic           none_wr,
  input  logic           all_wr,
  input  logic [CHW-1:0] sel,
  input  logic           set_bit,
  input  logic [NCH-1:0] load,
  output logic [NCH-1:0] mask
);
  logic [NCH-1:0] mask_d;

  always_comb begin
    mask_d = mask;
    if (master)  mask_d = '1;
    if (none_wr) mask_d = '0;
    if (all_wr)  mask_d = load;
    if (one_wr) begin
      for (int c = 0; c < NCH; c++) begin
        if (sel == CHW'(c)) mask_d[c] = set_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else        mask <= mask_d;
  end
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned SW  = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_wr,
  input  logic           master,
  input  logic           rd_clr,
  input  logic [CHW-1:0] sel,
  input  logic           set_bit,
  input  logic [NCH-1:0] hold,
  input  logic [NCH-1:0] release_r,
  input  logic [NCH-1:0] tc,
  output logic [SW-1:0]  status
);
  logic [SW-1:0] status_d;

  // Order of the updates is the priority: CPU actions first, external last.
  always_comb begin
    status_d = status;
    if (master) status_d = '0;
    if (rd_clr) status_d[NCH-1:0] = '0;
    for (int c = 0; c < NCH; c++) begin
      if (req_wr && (sel == CHW'(c))) begin
        status_d[NCH+c] = set_bit;
        status_d[c]     = 1'b0;
      end
      if (tc[c]) status_d[c] = 1'b1;
      if (hold[c])           status_d[NCH+c] = 1'b1;
      else if (release_r[c]) status_d[NCH+c] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end
endmodule

// File: rtl/dma_ctl_modes.sv
module dma_ctl_modes
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wr,
  input  logic [CHW-1:0]        sel,
  input  logic [DATA_W-1:0]     data,
  output logic [NCH*DATA_W-1:0] modes
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [DATA_W-1:0] mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mode_q <= '0;
      else if (mode_wr && (sel == CHW'(g)))    mode_q <= data;
    end
    assign modes[g*DATA_W +: DATA_W] = mode_q;
  end
endmodule

// File: rtl/dma_ctl_decoder.sv
module dma_ctl_decoder
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned SW  = 2 * NCH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      port_idx,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NCH-1:0]        hold_req,
  input  logic [NCH-1:0]        release_req,
  input  logic [NCH-1:0]        tc_done,
  output logic [NCH-1:0]        mask_out,
  output logic [NCH-1:0]        req_out,
  output logic [DATA_W-1:0]     cmd_out,
  output logic [NCH*DATA_W-1:0] mode_out,
  output logic                  ptr_clr
);
  wr_strobe_t        stb;
  logic              status_rd;
  logic [SW-1:0]     status_q;
  logic [DATA_W-1:0] cmd_q;
  logic              ptr_clr_q;
  logic              cmd_load;
  logic              ptr_clr_ev;
  logic [CHW-1:0]    chan_sel;
  logic              chan_set;

  assign chan_sel   = wr_data[CHW-1:0];
  assign chan_set   = wr_data[SETBIT_POS];
  assign cmd_load   = stb.command && cmd_is_legal(wr_data);
  assign ptr_clr_ev = stb.ptrclr || stb.master;

  dma_ctl_decode u_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_idx  (port_idx),
    .stb       (stb),
    .status_rd (status_rd)
  );

  dma_ctl_mask #(.NCH(NCH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .one_wr  (stb.onemask),
    .master  (stb.master),
    .none_wr (stb.masknone),
    .all_wr  (stb.maskall),
    .sel     (chan_sel),
    .set_bit (chan_set),
    .load    (wr_data[NCH-1:0]),
    .mask    (mask_out)
  );

  dma_ctl_status #(.NCH(NCH)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (stb.swreq),
    .master    (stb.master),
    .rd_clr    (status_rd),
    .sel       (chan_sel),
    .set_bit   (chan_set),
    .hold      (hold_req),
    .release_r (release_req),
    .tc        (tc_done),
    .status    (status_q)
  );

  dma_ctl_modes #(.NCH(NCH)) u_modes (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_wr (stb.mode),
    .sel     (chan_sel),
    .data    (wr_data),
    .modes   (mode_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      ptr_clr_q <= 1'b0;
    end else begin
      ptr_clr_q <= ptr_clr_ev;
      if (stb.master)    cmd_q <= '0;
      else if (cmd_load) cmd_q <= wr_data;
    end
  end

  assign cmd_out = cmd_q;
  assign ptr_clr = ptr_clr_q;
  assign req_out = status_q[SW-1:NCH];
  assign rd_data = (rd_en && !wr_en)
                 ? read_select(port_idx, DATA_W'(status_q), DATA_W'(mask_out))
                 : '0;
endmodule

// File: rtl/dma_ctl_decoder_chk.sv
module dma_ctl_decoder_chk
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [IDX_W-1:0]      port_idx,
  input logic [DATA_W-1:0]     wr_data,
  input logic [NCH-1:0]        hold_req,
  input logic [NCH-1:0]        release_req,
  input logic [NCH-1:0]        tc_done,
  input logic [NCH-1:0]        mask_out,
  input logic [NCH-1:0]        req_out,
  input logic [DATA_W-1:0]     cmd_out,
  input logic                  ptr_clr,
  input logic [2*NCH-1:0]      status_q
);
  // R2: an illegal command byte leaves the register as it was
  a_r2_reject_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_idx == P_COMMAND && (wr_data & ~CMD_HONOURED) != '0)
      |=> $stable(cmd_out));

  // R6: pointer clear follows a port 12 or 13 write, and only those
  a_r6_ptr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (port_idx == P_PTRCLR || port_idx == P_MASTER)) |=> ptr_clr);
  a_r6_ptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (port_idx == P_PTRCLR || port_idx == P_MASTER)) |=> !ptr_clr);

  // R7: master reset masks every channel and clears the command
  a_r7_master_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_idx == P_MASTER) |=> (mask_out == '1 && cmd_out == '0));

  // R9: a status read with no completion event leaves the low bits clear
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && port_idx == P_COMMAND && tc_done == '0)
      |=> status_q[NCH-1:0] == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R10 / R11: external hold and release win over any CPU action
    a_r10_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hold_req[c] |=> req_out[c]);
    a_r11_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (release_req[c] && !hold_req[c]) |=> !req_out[c]);
    // R12: a completion event always lands in the low status bit
    a_r12_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tc_done[c] |=> status_q[c]);
  end
endmodule

bind dma_ctl_decoder dma_ctl_decoder_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .port_idx    (port_idx),
  .wr_data     (wr_data),
  .hold_req    (hold_req),
  .release_req (release_req),
  .tc_done     (tc_done),
  .mask_out    (mask_out),
  .req_out     (req_out),
  .cmd_out     (cmd_out),
  .ptr_clr     (ptr_clr),
  .status_q    (status_q)
);

// File: tb/dma_ctl_decoder_test.sv
module dma_ctl_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  port_idx = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [3:0]  hold_req = '0;
  logic [3:0]  release_req = '0;
  logic [3:0]  tc_done = '0;
  logic [3:0]  mask_out;
  logic [3:0]  req_out;
  logic [7:0]  cmd_out;
  logic [31:0] mode_out;
  logic        ptr_clr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the registers, following the requirements.
  logic [7:0] m_cmd;
  logic [3:0] m_mask;
  logic [7:0] m_stat;
  logic [7:0] m_mode [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctl_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_idx(port_idx), .wr_data(wr_data), .rd_data(rd_data),
    .hold_req(hold_req), .release_req(release_req), .tc_done(tc_done),
    .mask_out(mask_out), .req_out(req_out), .cmd_out(cmd_out),
    .mode_out(mode_out), .ptr_clr(ptr_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [3:0] p, input logic [7:0] d,
                          input logic [3:0] h, input logic [3:0] r);
    case (p)
      4'd8:  if (d == 8'h00 || d == 8'h04) m_cmd = d;
      4'd9:  begin m_stat[4 + d[1:0]] = d[2]; m_stat[d[1:0]] = 1'b0; end
      4'd10: m_mask[d[1:0]] = d[2];
      4'd11: m_mode[d[1:0]] = d;
      4'd13: begin m_mask = 4'hF; m_stat = 8'h00; m_cmd = 8'h00; end
      4'd14: m_mask = 4'h0;
      4'd15: m_mask = d[3:0];
      default: ;
    endcase
    for (int c = 0; c < 4; c++) begin
      if (h[c])      m_stat[4 + c] = 1'b1;
      else if (r[c]) m_stat[4 + c] = 1'b0;
    end
  endtask

  // Write with optional same-cycle hold/release; returns at the following negedge.
  task automatic wr(input logic [3:0] p, input logic [7:0] d,
                    input logic [3:0] h = 4'h0, input logic [3:0] r = 4'h0);
    @(negedge clk);
    wr_en = 1'b1; port_idx = p; wr_data = d; hold_req = h; release_req = r;
    @(negedge clk);
    wr_en = 1'b0; hold_req = '0; release_req = '0;
    model_wr(p, d, h, r);
  endtask

  task automatic rd(input logic [3:0] p, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; port_idx = p;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    if (p == 4'd8) m_stat[3:0] = 4'h0;
  endtask

  task automatic ext(input logic [3:0] h, input logic [3:0] r, input logic [3:0] t);
    @(negedge clk);
    hold_req = h; release_req = r; tc_done = t;
    @(negedge clk);
    hold_req = '0; release_req = '0; tc_done = '0;
    for (int c = 0; c < 4; c++) begin
      if (t[c]) m_stat[c] = 1'b1;
    end
    model_wr(4'd0, 8'h00, h, r);
  endtask

  task automatic check_all(input string tag);
    chk(tag, {28'h0, mask_out}, {28'h0, m_mask});
    chk(tag, {28'h0, req_out}, {28'h0, m_stat[7:4]});
    chk(tag, {24'h0, cmd_out}, {24'h0, m_cmd});
    chk(tag, mode_out, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    m_cmd = 8'h00; m_mask = 4'hF; m_stat = 8'h00;
    for (int c = 0; c < 4; c++) m_mode[c] = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_all("R1");
    chk("R1", {31'h0, ptr_clr}, 32'h0);
    rd(4'd8, v);
    chk("R1", {24'h0, v}, 32'h0);

    // R2: every command value
    for (int d = 0; d < 256; d++) begin
      wr(4'd8, 8'(d));
      chk("R2", {24'h0, cmd_out}, {24'h0, m_cmd});
      if (d == 4) begin
        wr(4'd8, 8'h80);
        chk("R2", {24'h0, cmd_out}, 32'h04);
      end
    end

    // R4 / R8: single-mask codes against every starting mask
    for (int p = 0; p < 16; p++) begin
      for (int d = 0; d < 8; d++) begin
        wr(4'd15, 8'(p) | 8'hF0);
        chk("R8", {28'h0, mask_out}, p);
        wr(4'd10, 8'(d) | 8'hF8);
        chk("R4", {28'h0, mask_out}, {28'h0, m_mask});
      end
    end
    wr(4'd14, 8'hFF);
    chk("R8", {28'h0, mask_out}, 32'h0);

    // R5: mode bytes per channel, several rounds
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        wr(4'd11, {6'(r * 17 + c * 5 + 3), 2'(c)});
        check_all("R5");
      end
    end

    // R3: software request writes
    for (int d = 0; d < 8; d++) begin
      wr(4'd9, 8'(d));
      chk("R3", {28'h0, req_out}, {28'h0, m_stat[7:4]});
    end
    wr(4'd9, 8'h04); wr(4'd9, 8'h05); wr(4'd9, 8'h06); wr(4'd9, 8'h07);
    chk("R3", {28'h0, req_out}, 32'hF);

    // R12 / R9: completion events, read returns status, then low bits clear
    ext(4'h0, 4'h0, 4'b1010);
    rd(4'd8, v);
    chk("R12", {24'h0, v}, 32'hFA);
    rd(4'd8, v);
    chk("R9", {24'h0, v}, 32'hF0);
    ext(4'h0, 4'h0, 4'b0111);
    wr(4'd9, 8'h05);               // R3: clears status bit 1, keeps request 1 set
    rd(4'd8, v);
    chk("R3", {24'h0, v}, {24'h0, 8'hF5});
    rd(4'd8, v);
    chk("R9", {24'h0, v}, {24'h0, m_stat});
    wr(4'd15, 8'h09);
    rd(4'd15, v);
    chk("R9", {24'h0, v}, 32'h09);
    for (int p = 0; p < 16; p++) begin
      if (p != 8 && p != 15) begin
        rd(4'(p), v);
        chk("R9", {24'h0, v}, 32'h0);
      end
    end

    // R6: pointer clear pulse
    wr(4'd12, 8'hA5);
    chk("R6", {31'h0, ptr_clr}, 32'h1);
    @(negedge clk);
    chk("R6", {31'h0, ptr_clr}, 32'h0);
    check_all("R6");

    // R7: master reset
    wr(4'd8, 8'h04);
    ext(4'h3, 4'h0, 4'h1);
    wr(4'd13, 8'h5A);
    chk("R7", {31'h0, ptr_clr}, 32'h1);
    check_all("R7");
    rd(4'd8, v);
    chk("R7", {24'h0, v}, 32'h0);

    // R10: hold and release per channel
    for (int c = 0; c < 4; c++) begin
      ext(4'(1 << c), 4'h0, 4'h0);
      chk("R10", {28'h0, req_out}, {28'h0, m_stat[7:4]});
      ext(4'h0, 4'(1 << c), 4'h0);
      chk("R10", {28'h0, req_out}, {28'h0, m_stat[7:4]});
    end
    ext(4'h2, 4'h2, 4'h0);
    chk("R10", {28'h0, req_out}, 32'h2);

    // R11: external events beat CPU writes on the same bit
    wr(4'd9, 8'h00, 4'h1, 4'h0);
    chk("R11", {28'h0, req_out[0]}, 32'h1);
    wr(4'd9, 8'h05, 4'h0, 4'h2);
    chk("R11", {28'h0, req_out[1]}, 32'h0);
    wr(4'd13, 8'h00, 4'h8, 4'h0);
    chk("R11", {28'h0, req_out}, 32'h8);
    check_all("R11");

    // R12: completion event beats a same-cycle read clear
    @(negedge clk);
    rd_en = 1'b1; port_idx = 4'd8; tc_done = 4'h4;
    @(negedge clk);
    rd_en = 1'b0; tc_done = '0;
    m_stat[3:0] = 4'h4;
    rd(4'd8, v);
    chk("R12", {24'h0, v}, {24'h0, 8'h84});

    // R13: lower port indices have no effect
    wr(4'd15, 8'h06);
    wr(4'd8, 8'h04);
    for (int p = 0; p < 8; p++) begin
      wr(4'(p), 8'hFF);
      wr(4'(p), 8'h00);
      check_all("R13");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule